// File: doc/BRIEF.md
# Prescaled Reloading Countdown Timer

This block is an 8-bit down-counter placed in the peripheral space of a small processor. A strobe that pulses once per machine cycle times it. A narrow command port drives it: each command is a one-cycle pulse with an opcode and, for a load, a data byte. A fixed divide-by-32 prescaler turns the machine-cycle strobe into count ticks. When the counter passes through zero it restarts from the value last loaded, so it keeps cycling without any further commands.

Each pass through zero is a terminal event. The block routes that event one of two ways. In the default mode it sets a pending flag, and the flag drives an interrupt request whenever the interrupt is enabled. In toggle mode the event flips the Q output instead, which gives a free-running square wave. With a 64 µs count period, a reload value of 1 gives about 7.8 kHz and a reload value of 255 gives about 30 Hz. Software can read the live count at any time without disturbing it.

Top module: `cycle_countdown_timer`

## Requirements
- R1: Opcode 0 (LOAD) writes `cmd_data` into both the live count and the reload register on the next edge, also while the timer is running.
- R2: While running, the count goes down by one on every 32nd `mc_strobe` pulse. Strobes are ignored while the timer is stopped.
- R3: LOAD and opcode 1 (START) clear the prescaler, so the first decrement after either comes exactly 32 strobes later.
- R4: A tick that finds the count at 1 (or 0) loads the reload value instead of decrementing and raises a terminal event. With a reload of 1, every tick is a terminal event.
- R5: After opcode 4 (QMODE), each terminal event inverts `q_out` and leaves the pending flag untouched.
- R6: Opcode 2 (STOP) halts counting and leaves toggle mode. `q_out` keeps its level, and later events go back to the pending flag.
- R7: Opcode 3 (READ) puts the pre-edge count on `rd_data` with `rd_valid` high for one cycle. `rd_data` holds between reads, and a read never changes the count.
- R8: Outside toggle mode a terminal event sets the pending flag. Opcode 7 (ICLR) clears it. When an event and ICLR fall on the same edge, the flag ends up set.
- R9: `irq` is a registered output equal to pending AND enabled. Opcode 5 enables the interrupt and opcode 6 disables it. The flag still sets while the interrupt is disabled.
- R10: Synchronous reset clears the count, reload value, prescaler, run state, modes, the flag, `q_out`, `irq`, `rd_data` and `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_strobe | input | 1 | One pulse per machine cycle |
| cmd_valid | input | 1 | Command pulse |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 8 | Load value |
| rd_data | output | 8 | Count captured by the last READ |
| rd_valid | output | 1 | High one cycle after READ |
| q_out | output | 1 | Square-wave output |
| irq | output | 1 | Interrupt request |

## Verification
A prescaler that is off by one shifts every later terminal event, and the error builds up as the run goes on. It shows at `q_out` or `irq` on the first event, at most 32 strobes times the reload value after a start or load. A wrong reload or a wrong count shows at the next READ and changes the toggle period right away. A wrong routing of events between Q and the pending flag shows on the first event after a mode change. The reference model is compared with the outputs on every cycle, so each such fault appears within one event period.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_START = 3'd1,
    OP_STOP  = 3'd2,
    OP_READ  = 3'd3,
    OP_QMODE = 3'd4,
    OP_IEN   = 3'd5,
    OP_IDIS  = 3'd6,
    OP_ICLR  = 3'd7
  } op_e;

  typedef struct packed {
    logic load;
    logic start;
    logic stop;
    logic read;
    logic qmode;
    logic ien;
    logic idis;
    logic iclr;
  } cmd_t;
endpackage

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [CNT_W-1:0] cur_count,
  output cmd_t             cmd,
  output logic             running,
  output logic [CNT_W-1:0] rd_data,
  output logic             rd_valid
);
  always_comb begin
    cmd = '0;
    if (cmd_valid) begin
      unique case (op_e'(cmd_op))
        OP_LOAD:  cmd.load  = 1'b1;
        OP_START: cmd.start = 1'b1;
        OP_STOP:  cmd.stop  = 1'b1;
        OP_READ:  cmd.read  = 1'b1;
        OP_QMODE: cmd.qmode = 1'b1;
        OP_IEN:   cmd.ien   = 1'b1;
        OP_IDIS:  cmd.idis  = 1'b1;
        OP_ICLR:  cmd.iclr  = 1'b1;
        default:  cmd = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (cmd.start)
        running <= 1'b1;
      else if (cmd.stop)
        running <= 1'b0;
      rd_valid <= cmd.read;
      if (cmd.read)
        rd_data <= cur_count;
    end
  end

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd.read |=> rd_valid && rd_data == $past(cur_count)); // R7
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
    cmd.stop |=> !running); // R6
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic enable,
  output logic tick
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(DIV - 1);

  logic [PRE_W-1:0] pre;

  assign tick = enable && !clear && (pre == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear)
      pre <= '0;
    else if (enable) begin
      if (pre == LAST)
        pre <= '0;
      else
        pre <= pre + 1'b1;
    end
  end

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
    pre <= LAST); // R2
  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clear |=> pre == '0); // R3
  AST_PRE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !enable && !clear |=> $stable(pre)); // R2
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] reload;

  assign evt = tick && !load && (count <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      reload <= '0;
    end else if (load) begin
      count  <= load_val;
      reload <= load_val;
    end else if (tick) begin
      if (count <= ONE)
        count <= reload;
      else
        count <= count - ONE;
    end
  end

  AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (rst)
    load |=> count == $past(load_val) && reload == $past(load_val)); // R1
  AST_RELOAD_AT_END: assert property (@(posedge clk) disable iff (rst)
    evt |=> count == $past(reload)); // R4
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick && !load |=> $stable(count)); // R2
endmodule

// File: rtl/cdt_events.sv
module cdt_events
  import cdt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  cmd_t cmd,
  output logic q_out,
  output logic irq
);
  logic qmode, pend, ien;
  logic pend_n, ien_n;

  always_comb begin
    pend_n = (pend && !cmd.iclr) || (evt && !qmode);
    if (cmd.ien)
      ien_n = 1'b1;
    else if (cmd.idis)
      ien_n = 1'b0;
    else
      ien_n = ien;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qmode <= 1'b0;
      pend  <= 1'b0;
      ien   <= 1'b0;
      q_out <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (cmd.stop)
        qmode <= 1'b0;
      else if (cmd.qmode)
        qmode <= 1'b1;
      if (evt && qmode)
        q_out <= !q_out;
      pend <= pend_n;
      ien  <= ien_n;
      irq  <= pend_n && ien_n;
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> pend && ien); // R9
  AST_Q_STILL: assert property (@(posedge clk) disable iff (rst)
    !(evt && qmode) |=> $stable(q_out)); // R6
  AST_TOGGLE_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    evt && qmode && !pend |=> !pend); // R5
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
    evt && !qmode |=> pend); // R8
endmodule

// File: rtl/cycle_countdown_timer.sv
module cycle_countdown_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mc_strobe,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [CNT_W-1:0] cmd_data,
  output logic [CNT_W-1:0] rd_data,
  output logic             rd_valid,
  output logic             q_out,
  output logic             irq
);
  cmd_t             cmd;
  logic             running;
  logic             tick;
  logic             evt;
  logic [CNT_W-1:0] count;

  cdt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cur_count (count),
    .cmd       (cmd),
    .running   (running),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  cdt_prescaler #(.DIV(DIV)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clear  (cmd.load || cmd.start),
    .enable (running && mc_strobe),
    .tick   (tick)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cmd.load),
    .load_val (cmd_data),
    .tick     (tick),
    .count    (count),
    .evt      (evt)
  );

  cdt_events u_evt (
    .clk   (clk),
    .rst   (rst),
    .evt   (evt),
    .cmd   (cmd),
    .q_out (q_out),
    .irq   (irq)
  );

  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !running |-> !tick); // R2
endmodule

// File: tb/test_cycle_countdown_timer.sv
module test_cycle_countdown_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0;
  logic       cv = 1'b0;
  logic [2:0] cop = 3'd0;
  logic [7:0] cd = 8'd0;
  logic [7:0] rd_data;
  logic       rd_valid, q_out, irq;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int m_cnt = 0, m_rel = 0, m_pre = 0, m_rdd = 0;
  bit m_run = 0, m_qm = 0, m_q = 0, m_pend = 0, m_ien = 0, m_irq = 0, m_rdv = 0;

  always #5 clk = ~clk;

  cycle_countdown_timer i_cycle_countdown_timer (
    .clk(clk), .rst(rst), .mc_strobe(cs), .cmd_valid(cv), .cmd_op(cop),
    .cmd_data(cd), .rd_data(rd_data), .rd_valid(rd_valid), .q_out(q_out), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit ev, tk, old_qm;
    int old_cnt;
    if (rst) begin
      m_cnt = 0; m_rel = 0; m_pre = 0; m_rdd = 0; m_run = 0; m_qm = 0;
      m_q = 0; m_pend = 0; m_ien = 0; m_irq = 0; m_rdv = 0;
    end else begin
      ev = 0; tk = 0; old_qm = m_qm; old_cnt = m_cnt;
      if (m_run && cs && !(cv && (cop == 0 || cop == 1))) begin
        if (m_pre == 31) begin m_pre = 0; tk = 1; end
        else m_pre++;
      end
      if (tk && !(cv && cop == 0)) begin
        if (m_cnt <= 1) begin m_cnt = m_rel; ev = 1; end
        else m_cnt--;
      end
      m_rdv = cv && cop == 3;
      if (m_rdv) m_rdd = old_cnt;
      if (cv && cop == 7) m_pend = 0;
      if (ev) begin
        if (old_qm) m_q = !m_q;
        else m_pend = 1;
      end
      if (cv) begin
        case (cop)
          3'd0: begin m_cnt = cd; m_rel = cd; m_pre = 0; end
          3'd1: begin m_run = 1; m_pre = 0; end
          3'd2: begin m_run = 0; m_qm = 0; end
          3'd4: m_qm = 1;
          3'd5: m_ien = 1;
          3'd6: m_ien = 0;
          default: ;
        endcase
      end
      m_irq = m_pend && m_ien;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R5 q_out model", q_out, m_q);
      check("R9 irq model", irq, m_irq);
      check("R7 rd_valid model", rd_valid, m_rdv);
      check("R7 rd_data model", rd_data, m_rdd);
    end
  end

  task automatic step(input bit v, input int op, input int d, input bit s);
    @(negedge clk);
    cv = v; cop = 3'(op); cd = 8'(d); cs = s;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1);
  endtask

  task automatic idle();
    step(0, 0, 0, 0);
  endtask

  task automatic do_read(input string req, input int exp);
    step(1, 3, 0, 0);
    idle();
    check(req, rd_data, exp);
    check(req, rd_valid, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    check("R10 q_out reset", q_out, 0);
    check("R10 irq reset", irq, 0);
    check("R10 rd_valid reset", rd_valid, 0);
    check("R10 rd_data reset", rd_data, 0);

    step(1, 0, 3, 0);                       // R1 load 3
    do_read("R1 load value", 3);
    idle();
    check("R7 rd_valid drops", rd_valid, 0);
    check("R7 rd_data holds", rd_data, 3);

    step(1, 1, 0, 0);                       // start
    strobes(31);
    do_read("R3 no tick before 32 strobes", 3);
    strobes(1);
    do_read("R2 decrement at strobe 32", 2);

    strobes(64);                            // terminal event, interrupt disabled
    idle();
    check("R9 masked irq", irq, 0);
    step(1, 5, 0, 0); idle();
    check("R9 irq after enable", irq, 1);
    step(1, 6, 0, 0); idle();
    check("R9 irq after disable", irq, 0);
    step(1, 5, 0, 0); idle();
    check("R8 flag kept", irq, 1);
    step(1, 7, 0, 0); idle();
    check("R8 flag cleared", irq, 0);
    do_read("R4 reloaded count", 3);

    step(1, 4, 0, 0);                       // toggle mode
    strobes(96);
    idle();
    check("R5 q toggled", q_out, 1);
    check("R5 no irq in toggle mode", irq, 0);

    step(1, 0, 1, 0);                       // reload 1
    strobes(32); idle();
    check("R4 reload 1 toggles each tick", q_out, 0);
    strobes(32); idle();
    check("R4 reload 1 toggles again", q_out, 1);

    step(1, 0, 5, 0);                       // R1 load while running
    strobes(32);
    do_read("R1 load while running", 4);

    step(1, 2, 0, 0);                       // stop
    strobes(40);
    do_read("R6 count frozen", 4);
    check("R6 q holds", q_out, 1);

    step(1, 1, 0, 0);                       // restart, toggle mode now off
    strobes(128);
    idle();
    check("R6 event goes to flag", irq, 1);
    check("R6 q unchanged", q_out, 1);

    step(1, 7, 0, 0);
    for (int i = 0; i < 200; i++) step(0, 0, 0, i[0]);   // R2 sparse strobes
    do_read("R2 sparse strobes", 2);

    step(1, 0, 1, 0);                       // R8 event and clear together
    strobes(31);
    step(1, 7, 0, 1);
    idle();
    check("R8 event wins over clear", irq, 1);

    idle();
    finish_run();
  end
endmodule